// File: doc/BRIEF.md
# Memory-Mapped System Counter

This block is a free-running system timestamp counter behind a small register port. Software turns the count on and off through a control register. It can arm a halt-on-debug control that stops the count while an external debug request is high, and it can read a status flag that shows when such a halt is in effect. The count is read either as one 64-bit access or as two 32-bit halves. A shadow of the upper half keeps a low-then-high pair of reads consistent across a carry. A base-frequency word is held for firmware to read.

Each clock with counting allowed adds a parameterised step to the count. While counting is off, the count holds its value, and it resumes from that value when counting is turned back on. Reads are always answered with an okay response. A write that lacks the secure attribute is dropped and answered with an error. The port accepts one request per cycle, and the answer appears on the response outputs one cycle after acceptance.

Top module: `sysctr_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, both count halves and the 64-bit count read 0, the upper-half shadow is 0, and the frequency word reads the FREQ_RESET parameter.
- R2: While control bit 0 is 1 and no debug halt is in effect, the count grows by STEP on every clock. The first growth comes on the clock after the edge that accepts the enabling write.
- R3: While control bit 0 is 0, the count holds its value. After counting is turned back on, the count continues from the held value and does not jump ahead by the time spent off.
- R4: While control bit 1 is 1 and `dbg_halt_req` is high, the count holds and status bit 1 reads 1. In every other case status bit 1 reads 0. All other status bits read 0.
- R5: A 32-bit read (req_size 0) at offset 0x08 returns count bits 31:0 and copies count bits 63:32 into the shadow. A read at offset 0x0C returns the shadow, not the live upper half.
- R6: A 64-bit read (req_size 1) at offset 0x08 returns the full count and leaves the shadow unchanged. Every other read returns its 32-bit value zero-extended.
- R7: A write with req_secure 0 gets rsp_err 1 and changes no register.
- R8: Every accepted request produces exactly one cycle of rsp_valid on the following cycle. Reads always return rsp_err 0, secure or not.
- R9: A secure write to offset 0x00 sets control bits 1:0 from write data bits 1:0, and the other control bits read 0. A secure write to offset 0x20 replaces the frequency word with write data bits 31:0.
- R10: Offsets other than 0x00, 0x04, 0x08, 0x0C and 0x20 read 0. A secure write to any offset other than 0x00 or 0x20 is answered okay and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 1 | 0 = 32-bit access, 1 = 64-bit access |
| req_secure | input | 1 | Secure attribute of the access |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| dbg_halt_req | input | 1 | External debug halt request |

## Verification
The bench builds the block with STEP set to 0x1000_0001 rather than 1, so the upper 32 bits of the count change every sixteen clocks. This puts carries into the upper half, and the difference between the shadow and the live upper half, within a few hundred cycles. FREQ_RESET is set to a non-zero pattern so that the reset value of the frequency word can be told apart from zero. Random accesses mix secure and non-secure attributes, random debug requests and idle gaps. They are checked against a cycle-level model of the register map.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

    // Register offsets; software decodes these, so they are fixed.
    localparam int unsigned OFS_CTRL   = 32'h00;
    localparam int unsigned OFS_STAT   = 32'h04;
    localparam int unsigned OFS_CNT_LO = 32'h08;
    localparam int unsigned OFS_CNT_HI = 32'h0C;
    localparam int unsigned OFS_FREQ   = 32'h20;

    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } acc_size_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_FREQ
    } reg_sel_e;

    typedef struct packed {
        logic hdbg;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/sysctr_decode.sv
module sysctr_decode
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL)) begin
            sel = SEL_CTRL;
        end else if (addr == ADDR_W'(OFS_STAT)) begin
            sel = SEL_STAT;
        end else if (addr == ADDR_W'(OFS_CNT_LO)) begin
            sel = SEL_CNT_LO;
        end else if (addr == ADDR_W'(OFS_CNT_HI)) begin
            sel = SEL_CNT_HI;
        end else if (addr == ADDR_W'(OFS_FREQ)) begin
            sel = SEL_FREQ;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/sysctr_core.sv
module sysctr_core #(
    parameter int unsigned       CNT_W = 64,
    parameter logic [CNT_W-1:0]  STEP  = CNT_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             hdbg_en,
    input  logic             dbg_req,
    output logic [CNT_W-1:0] count_o,
    output logic             halted_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        halted;
    logic        tick;

    always_comb begin
        halted = hdbg_en && dbg_req;
        tick   = run_en && !halted;
        st_d   = st_q;
        if (tick) begin
            st_d.count = st_q.count + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign halted_o = halted;

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> count_o == $past(count_o)); // R3

    AST_HOLD_ON_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (hdbg_en && dbg_req) |=> count_o == $past(count_o)); // R4

    AST_STEP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !halted_o) |=> count_o == $past(count_o) + STEP); // R2

    always_comb begin
        AST_HALT_NEEDS_ARM: assert (!halted_o || hdbg_en); // R4
    end

endmodule

// File: rtl/sysctr_regs.sv
module sysctr_regs
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned CNT_W      = 64,
    parameter logic [31:0] FREQ_RESET = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    input  logic              req_secure,
    input  logic [63:0]       req_wdata,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              halted_i,
    output logic              ctrl_en_o,
    output logic              ctrl_hdbg_o,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata
);

    localparam int unsigned HI_W = 32;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [31:0]      freq;
        logic [HI_W-1:0]  shadow;
        logic             rsp_valid;
        logic             rsp_err;
        logic [63:0]      rdata;
    } reg_state_t;

    reg_state_t  st_d, st_q;
    reg_sel_e    sel;
    logic        acc;
    logic [63:0] cnt64;
    acc_size_e   size;

    sysctr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    always_comb begin
        acc   = req_valid;
        cnt64 = 64'(count_i);
        size  = acc_size_e'(req_size);

        st_d           = st_q;
        st_d.rsp_valid = acc;
        st_d.rsp_err   = 1'b0;
        st_d.rdata     = '0;

        if (acc) begin
            if (req_write) begin
                if (!req_secure) begin
                    st_d.rsp_err = 1'b1;
                end else begin
                    case (sel)
                        SEL_CTRL: begin
                            st_d.ctrl.en   = req_wdata[0];
                            st_d.ctrl.hdbg = req_wdata[1];
                        end
                        SEL_FREQ: st_d.freq = req_wdata[31:0];
                        default:  ;
                    endcase
                end
            end else begin
                case (sel)
                    SEL_CTRL: st_d.rdata = {62'b0, st_q.ctrl.hdbg, st_q.ctrl.en};
                    SEL_STAT: st_d.rdata = {62'b0, halted_i, 1'b0};
                    SEL_CNT_LO: begin
                        if (size == SZ_DWORD) begin
                            st_d.rdata = cnt64;
                        end else begin
                            st_d.rdata  = {32'b0, cnt64[31:0]};
                            st_d.shadow = cnt64[63:32];
                        end
                    end
                    SEL_CNT_HI: st_d.rdata = {32'b0, st_q.shadow};
                    SEL_FREQ:   st_d.rdata = {32'b0, st_q.freq};
                    default:    st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.freq <= FREQ_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_en_o   = st_q.ctrl.en;
    assign ctrl_hdbg_o = st_q.ctrl.hdbg;
    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_err     = st_q.rsp_err;
    assign rsp_rdata   = st_q.rdata;

    AST_NS_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure) |=> (rsp_valid && rsp_err)); // R7

    AST_NS_WRITE_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure)
        |=> ($stable(st_q.ctrl) && $stable(st_q.freq) && $stable(st_q.shadow))); // R7

    AST_READ_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_valid && !rsp_err)); // R8

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R8

    AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_secure && sel != SEL_CTRL && sel != SEL_FREQ)
        |=> ($stable(st_q.ctrl) && $stable(st_q.freq) && !rsp_err)); // R10

    AST_WIDE_READ_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel == SEL_CNT_LO && req_size)
        |=> $stable(st_q.shadow)); // R6

endmodule

// File: rtl/sysctr_top.sv
module sysctr_top #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned CNT_W      = 64,
    parameter logic [63:0] STEP       = 64'd1,
    parameter logic [31:0] FREQ_RESET = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    input  logic              req_secure,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    input  logic              dbg_halt_req
);

    localparam logic [CNT_W-1:0] STEP_W = CNT_W'(STEP);

    logic [CNT_W-1:0] count;
    logic             halted;
    logic             ctrl_en;
    logic             ctrl_hdbg;

    assign req_ready = 1'b1;

    sysctr_core #(
        .CNT_W (CNT_W),
        .STEP  (STEP_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (ctrl_en),
        .hdbg_en  (ctrl_hdbg),
        .dbg_req  (dbg_halt_req),
        .count_o  (count),
        .halted_o (halted)
    );

    sysctr_regs #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .FREQ_RESET (FREQ_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_secure  (req_secure),
        .req_wdata   (req_wdata),
        .count_i     (count),
        .halted_i    (halted),
        .ctrl_en_o   (ctrl_en),
        .ctrl_hdbg_o (ctrl_hdbg),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: tb/tb_sysctr_top.sv
`timescale 1ns/1ps
module tb_sysctr_top;

    localparam int unsigned ADDR_W = 12;
    localparam logic [63:0] STEP   = 64'h0000_0000_1000_0001;
    localparam logic [31:0] FREQ0  = 32'h05F5_E100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_size = 1'b0;
    logic              req_secure = 1'b0;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [63:0]       rsp_rdata;
    logic              dbg_halt_req = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sysctr_top #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (64),
        .STEP       (STEP),
        .FREQ_RESET (FREQ0)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_secure   (req_secure),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .dbg_halt_req (dbg_halt_req)
    );

    // Reference model built from the requirements
    logic [63:0] m_cnt;
    logic [31:0] m_shadow;
    logic [31:0] m_freq;
    logic        m_en;
    logic        m_hdbg;
    logic [63:0] m_exp_rdata;
    logic        m_exp_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_shadow = '0; m_freq = FREQ0;
            m_en = 1'b0; m_hdbg = 1'b0;
            m_exp_rdata = '0; m_exp_err = 1'b0;
        end else begin
            logic halted;
            logic inc;
            halted = m_hdbg && dbg_halt_req;
            inc    = m_en && !halted;
            if (req_valid) begin
                m_exp_rdata = '0;
                m_exp_err   = 1'b0;
                if (req_write) begin
                    if (!req_secure) begin
                        m_exp_err = 1'b1;
                    end else if (req_addr == 12'h000) begin
                        m_en   = req_wdata[0];
                        m_hdbg = req_wdata[1];
                    end else if (req_addr == 12'h020) begin
                        m_freq = req_wdata[31:0];
                    end
                end else begin
                    case (req_addr)
                        12'h000: m_exp_rdata = {62'b0, m_hdbg, m_en};
                        12'h004: m_exp_rdata = {62'b0, halted, 1'b0};
                        12'h008: begin
                            if (req_size) begin
                                m_exp_rdata = m_cnt;
                            end else begin
                                m_exp_rdata = {32'b0, m_cnt[31:0]};
                                m_shadow    = m_cnt[63:32];
                            end
                        end
                        12'h00C: m_exp_rdata = {32'b0, m_shadow};
                        12'h020: m_exp_rdata = {32'b0, m_freq};
                        default: m_exp_rdata = '0;
                    endcase
                end
            end
            if (inc) m_cnt = m_cnt + STEP;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input string tag, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic sz, input logic sec, input logic [63:0] wd,
                       output logic [63:0] rd);
        logic [63:0] er;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = sz; req_secure = sec; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        er = {63'b0, rsp_err};
        check({tag, " R8 rsp_valid"}, {63'b0, rsp_valid}, 64'd1);
        check({tag, " err"}, er, {63'b0, m_exp_err});
        if (!wr) check({tag, " rdata"}, rd, m_exp_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd, a, b, c;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values, checked against constants
        bus("R1 ctrl", 0, 12'h000, 0, 1, 0, rd); check("R1 ctrl", rd, 64'd0);
        bus("R1 stat", 0, 12'h004, 0, 0, 0, rd); check("R1 stat", rd, 64'd0);
        bus("R1 cnt64", 0, 12'h008, 1, 0, 0, rd); check("R1 cnt64", rd, 64'd0);
        bus("R1 hi", 0, 12'h00C, 0, 0, 0, rd); check("R1 shadow", rd, 64'd0);
        bus("R1 freq", 0, 12'h020, 0, 0, 0, rd); check("R1 freq", rd, {32'b0, FREQ0});
        idle(1);
        check("R8 idle no rsp", {63'b0, rsp_valid}, 64'd0);

        // R9 / R2 enable and count
        bus("R9 en", 1, 12'h000, 0, 1, 64'hFFFF_FFFF_FFFF_FFFD, rd);
        bus("R9 ctrl rd", 0, 12'h000, 0, 0, 0, rd); check("R9 ctrl bits", rd, 64'd1);
        bus("R2 cnt a", 0, 12'h008, 1, 1, 0, a);
        bus("R2 cnt b", 0, 12'h008, 1, 1, 0, b);
        check("R2 step between back-to-back reads", b - a, STEP * 2);

        // R5 shadow against a live carry
        bus("R5 lo", 0, 12'h008, 0, 1, 0, a);
        idle(40);
        bus("R5 hi shadow", 0, 12'h00C, 0, 0, 0, b);
        bus("R6 live", 0, 12'h008, 1, 0, 0, c);
        bus("R6 shadow kept", 0, 12'h00C, 0, 0, 0, rd);
        check("R6 shadow unchanged by wide read", rd, b);
        check("R5 shadow differs from live top", {63'b0, c[63:32] != b[31:0]}, 64'd1);

        // R7 non-secure write
        bus("R7 ns ctrl", 1, 12'h000, 0, 0, 64'd0, rd);
        bus("R7 ctrl kept", 0, 12'h000, 0, 0, 0, rd); check("R7 ctrl kept", rd, 64'd1);
        bus("R7 ns freq", 1, 12'h020, 0, 0, 64'h1234, rd);
        bus("R7 freq kept", 0, 12'h020, 0, 0, 0, rd); check("R7 freq kept", rd, {32'b0, FREQ0});

        // R3 freeze and resume
        bus("R3 off", 1, 12'h000, 0, 1, 64'd0, rd);
        bus("R3 a", 0, 12'h008, 1, 0, 0, a);
        idle(30);
        bus("R3 b", 0, 12'h008, 1, 0, 0, b);
        check("R3 frozen", b, a);
        bus("R3 on", 1, 12'h000, 0, 1, 64'd1, rd);
        idle(5);
        bus("R3 c", 0, 12'h008, 1, 0, 0, c);
        check("R3 no jump", {63'b0, (c - a) <= STEP * 8}, 64'd1);

        // R4 halt on debug
        bus("R4 arm", 1, 12'h000, 0, 1, 64'd3, rd);
        @(negedge clk); dbg_halt_req = 1'b1;
        bus("R4 stat", 0, 12'h004, 0, 0, 0, rd); check("R4 halted flag", rd, 64'd2);
        bus("R4 a", 0, 12'h008, 1, 0, 0, a);
        idle(10);
        bus("R4 b", 0, 12'h008, 1, 0, 0, b); check("R4 held", b, a);
        @(negedge clk); dbg_halt_req = 1'b0;
        bus("R4 stat clr", 0, 12'h004, 0, 0, 0, rd); check("R4 flag clear", rd, 64'd0);

        // R9 frequency word
        bus("R9 freq wr", 1, 12'h020, 0, 1, 64'hDEAD_BEEF_0BAD_F00D, rd);
        bus("R9 freq rd", 0, 12'h020, 0, 0, 0, rd); check("R9 freq", rd, 64'h0BAD_F00D);

        // R10 unmapped and read-only
        bus("R10 unmapped rd", 0, 12'h010, 0, 0, 0, rd); check("R10 unmapped zero", rd, 64'd0);
        bus("R10 unmapped wr", 1, 12'h010, 0, 1, 64'hFF, rd);
        check("R10 unmapped wr okay", {63'b0, rsp_err}, 64'd0);
        bus("R10 cnt wr", 1, 12'h008, 1, 1, 64'h5555, rd);
        bus("R10 stat wr", 1, 12'h004, 0, 1, 64'hFF, rd);
        bus("R10 ctrl intact", 0, 12'h000, 0, 0, 0, rd); check("R10 ctrl intact", rd, 64'd3);
        bus("R10 cnt follows model", 0, 12'h008, 1, 0, 0, rd);

        // Random mix checked against the model (R2..R10)
        for (int i = 0; i < 400; i++) begin
            logic [2:0] pick;
            logic [ADDR_W-1:0] ad;
            pick = 3'($urandom_range(0, 6));
            case (pick)
                3'd0: ad = 12'h000;
                3'd1: ad = 12'h004;
                3'd2, 3'd6: ad = 12'h008;
                3'd3: ad = 12'h00C;
                3'd4: ad = 12'h020;
                default: ad = 12'($urandom_range(0, 15) * 4);
            endcase
            @(negedge clk);
            dbg_halt_req = ($urandom_range(0, 3) == 0);
            bus("R2-random", ($urandom_range(0, 4) == 0), ad, 1'($urandom),
                1'($urandom), {$urandom, $urandom}, rd);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 6));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule